// File: doc/BRIEF.md
# Instruction fetch-decode sequencer

This block is the timing and decode front end of a small 16-bit accumulator machine. A sequence counter, cleared at reset or on request, steps through four one-hot timing phases. In the first three phases the block fetches the next instruction from a synchronous-read memory and moves its address field into the address register. In the fourth phase it reports the instruction's class.

The fetch runs as follows:
- The first phase copies the program counter into the address register.
- The second phase loads the instruction register from memory and advances the program counter.
- The third phase copies the 12-bit address field into the address register.

The opcode field (bits 14..12) feeds a 3-to-8 decoder. Bit 15 is the indirect flag.

In the fourth phase, opcode 111 marks a register-reference instruction when the indirect flag is clear, and an input-output instruction when it is set. Any other opcode is a memory reference. For an indirect memory reference the block replaces the address register with the low 12 bits of the memory word it points to, so the effective address sits in the register after the fourth phase. Execution past that point belongs to neighbouring logic. That logic ends each instruction by pulsing the counter-clear input.

The memory port presents the address the address register is about to take. A synchronous memory therefore returns the needed word in the following cycle.

Top module: `fetch_decode_seq`

## Requirements
- R1: While `rst_n` is low, the counter holds 0 (`t_out` = 4'b0001), and `pc`, `ar` and `ir` read 0.
- R2: The counter advances by one every cycle that `sc_clr` is low. `t_out[k]` is high exactly when the count equals k (k = 0..3). Past 3, `t_out` is all zero, and the counter saturates at its maximum instead of wrapping.
- R3: A cycle with `sc_clr` high makes the next cycle phase 0 (`t_out` = 4'b0001).
- R4: During phase 0, `mem_addr` equals `pc`. At the end of phase 0, `ar` takes the value of `pc`.
- R5: At the end of phase 1, `ir` takes `mem_rdata` and `pc` increments by one, modulo 4096.
- R6: At the end of phase 2, `ar` takes `ir[11:0]`. During phase 2, `mem_addr` equals `ir[11:0]`.
- R7: `dec[k]` is high exactly when `ir[14:12]` equals k, so `dec[7]` marks opcode 111. `ind` equals `ir[15]`.
- R8: The class strobes are high only in phase 3, and exactly one is high there:
  - `cls_mref` when the opcode is not 111;
  - `cls_rref` when the opcode is 111 and `ind` is 0;
  - `cls_io` when the opcode is 111 and `ind` is 1.
- R9: For an indirect memory reference, at the end of phase 3 `ar` takes `mem_rdata[11:0]`, the word at the address `ar` held.
- R10: For a direct memory reference, a register-reference or an input-output instruction, `ar` is unchanged at the end of phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_clr | input | 1 | Clear the sequence counter at the next edge |
| mem_addr | output | 12 | Read address for the synchronous memory |
| mem_rdata | input | 16 | Memory word, one cycle after its address |
| t_out | output | 4 | One-hot timing phases 0..3 |
| dec | output | 8 | Opcode decoder lines |
| ind | output | 1 | Indirect flag of the held instruction |
| cls_mref | output | 1 | Memory-reference strobe, phase 3 |
| cls_rref | output | 1 | Register-reference strobe, phase 3 |
| cls_io | output | 1 | Input-output strobe, phase 3 |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |

## Verification
The bench runs every opcode with both indirect settings. A design that keyed the class on the wrong decoder line, or ignored the indirect flag, would raise the wrong strobe in phase 3.

Pointer words carry ones in their upper nibble. A design that read the pointer in the wrong cycle, or did not truncate it to 12 bits, would leave a wrong effective address in `ar`. The same check catches a design that also rewrote `ar` for direct or opcode-111 instructions.

One instruction is held twenty cycles past phase 3. A wrapping counter would raise phase 0 again on its own, and the expected timing pattern would show it.

// File: rtl/fetch_decode_seq.sv
module fetch_decode_seq #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 3,
  parameter int SC_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sc_clr,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic [WORD_W-1:0]         mem_rdata,
  output logic [3:0]                t_out,
  output logic [(1<<OP_W)-1:0]      dec,
  output logic                      ind,
  output logic                      cls_mref,
  output logic                      cls_rref,
  output logic                      cls_io,
  output logic [ADDR_W-1:0]         pc,
  output logic [ADDR_W-1:0]         ar,
  output logic [WORD_W-1:0]         ir
);
  localparam int NUM_OPS = 1 << OP_W;
  localparam int OP_LO   = ADDR_W;
  localparam int OP_HI   = ADDR_W + OP_W - 1;
  localparam int IND_BIT = WORD_W - 1;
  localparam logic [SC_W-1:0] SC_MAX = '1;

  logic [SC_W-1:0] sc;
  logic [OP_W-1:0] opcode;
  logic            reg_io_op;

  always_ff @(posedge clk) begin
    if (!rst_n || sc_clr) sc <= '0;
    else if (sc != SC_MAX) sc <= sc + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_t
      assign t_out[gi] = (sc == SC_W'(gi));
    end
    for (gi = 0; gi < NUM_OPS; gi++) begin : g_dec
      assign dec[gi] = (opcode == OP_W'(gi));
    end
  endgenerate

  assign opcode    = ir[OP_HI:OP_LO];
  assign ind       = ir[IND_BIT];
  assign reg_io_op = dec[NUM_OPS-1];

  assign cls_mref = t_out[3] & ~reg_io_op;
  assign cls_rref = t_out[3] &  reg_io_op & ~ind;
  assign cls_io   = t_out[3] &  reg_io_op &  ind;

  assign mem_addr = t_out[0] ? pc :
                    t_out[2] ? ir[ADDR_W-1:0] : ar;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ar <= '0;
      ir <= '0;
    end else begin
      if (t_out[0]) ar <= pc;
      if (t_out[1]) begin
        ir <= mem_rdata;
        pc <= pc + 1'b1;
      end
      if (t_out[2]) ar <= ir[ADDR_W-1:0];
      if (cls_mref && ind) ar <= mem_rdata[ADDR_W-1:0];
    end
  end

  assert_t_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_out));
  assert_clear_to_t0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sc_clr |=> t_out[0]);
  assert_ar_from_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    t_out[0] |=> ar == $past(pc));
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    t_out[1] |=> pc == $past(pc) + ADDR_W'(1));
  assert_ar_from_ir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t_out[2] |=> ar == $past(ir[ADDR_W-1:0]));
  assert_one_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cls_mref, cls_rref, cls_io}) == (t_out[3] ? 1 : 0));
  assert_indirect_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_mref && ind) |=> ar == $past(mem_rdata[ADDR_W-1:0]));
  assert_ar_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (t_out[3] && !(cls_mref && ind)) |=> $stable(ar));
endmodule

// File: tb/tb_fetch_decode_seq.sv
module tb_fetch_decode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sc_clr = 1'b0;
  logic [11:0] mem_addr, pc, ar;
  logic [15:0] mem_rdata, ir;
  logic [3:0]  t_out;
  logic [7:0]  dec;
  logic ind, cls_mref, cls_rref, cls_io;

  always #2 clk = ~clk;

  fetch_decode_seq dut (
    .clk(clk), .rst_n(rst_n), .sc_clr(sc_clr), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .t_out(t_out), .dec(dec), .ind(ind),
    .cls_mref(cls_mref), .cls_rref(cls_rref), .cls_io(cls_io),
    .pc(pc), .ar(ar), .ir(ir));

  logic [15:0] mem [0:4095];
  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  typedef struct {
    logic [15:0] instr;
    logic [11:0] fetch_pc;
    logic [11:0] ar_final;
  } item_t;
  item_t sb[$];

  int errors = 0;
  int checks = 0;
  int k = 0;
  logic [11:0] pc_m = 12'h000;

  always @(posedge clk) k <= (!rst_n || sc_clr) ? 0 : k + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] instr, input logic [15:0] ptrw, input int hold);
    item_t it;
    logic mref_ind;
    mref_ind = (instr[14:12] != 3'b111) && instr[15];
    mem[pc_m] = instr;
    mem[instr[11:0]] = ptrw;
    it.instr = instr;
    it.fetch_pc = pc_m;
    it.ar_final = mref_ind ? ptrw[11:0] : instr[11:0];
    sb.push_back(it);
    pc_m = pc_m + 12'd1;
    repeat (4 + hold) @(negedge clk);
    sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      chk("R1 t_out", t_out, 4'b0001);
      chk("R1 pc", pc, 0);
      chk("R1 ar", ar, 0);
      chk("R1 ir", ir, 0);
    end else begin
      chk("R2/R3 t_out", t_out, (k < 4) ? (32'd1 << k) : 32'd0);
      if (sb.size() > 0) begin
        item_t it;
        logic [2:0] op;
        it = sb[0];
        op = it.instr[14:12];
        case (k)
          0: begin
            chk("R4 mem_addr", mem_addr, it.fetch_pc);
            chk("R4 pc", pc, it.fetch_pc);
          end
          1: chk("R4 ar", ar, it.fetch_pc);
          2: begin
            chk("R5 ir", ir, it.instr);
            chk("R5 pc", pc, it.fetch_pc + 12'd1);
            chk("R6 mem_addr", mem_addr, it.instr[11:0]);
          end
          3: begin
            chk("R6 ar", ar, it.instr[11:0]);
            chk("R7 dec", dec, 8'd1 << op);
            chk("R7 ind", ind, it.instr[15]);
            chk("R8 classes", {cls_mref, cls_rref, cls_io},
                (op != 3'b111) ? 3'b100 : (it.instr[15] ? 3'b001 : 3'b010));
          end
          4: begin
            chk("R9/R10 ar", ar, it.ar_final);
            void'(sb.pop_front());
          end
          default: ;
        endcase
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(16'h0210, 16'hF345, 0);  // R9 not applied: direct
    run(16'h8220, 16'hA456, 0);  // R9 indirect, opcode 0
    run(16'h1230, 16'hB567, 0);
    run(16'h9240, 16'hC678, 0);
    run(16'h2250, 16'hD789, 1);
    run(16'hA260, 16'hE89A, 0);
    run(16'h3270, 16'h1111, 0);
    run(16'hB280, 16'h2222, 2);
    run(16'h4290, 16'h3333, 0);
    run(16'hC2A0, 16'hF0F0, 0);
    run(16'h52B0, 16'h4444, 0);
    run(16'hD2C0, 16'hFFFF, 0);
    run(16'h62D0, 16'h5555, 0);
    run(16'hE2E0, 16'h9ABC, 0);
    run(16'h7800, 16'hFFFF, 0);  // R8 register-reference, R10
    run(16'h7001, 16'hEEEE, 0);
    run(16'hF400, 16'hDDDD, 0);  // R8 input-output, R10
    run(16'hF080, 16'hCCCC, 0);
    run(16'h8300, 16'hFABC, 20); // R2 saturation over long hold
    run(16'h0310, 16'h0777, 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule